// File: doc/BRIEF.md
# Vector Type Check and Maximum Length Unit

This block reads a vector type word and reports two things one cycle later. The first is whether the configuration is usable. The second is the largest element count that a register group can hold under that configuration, for a vector register width set by the parameter `VLEN`.

The type word carries two codes. One selects the element width, and one selects the group multiplier as a signed power-of-two exponent, which can be fractional. The maximum length is found with one right shift of `VLEN`.

A per-register select limits the result to what a single register holds. This serves consumers that walk a group one register at a time. An external invalid-configuration flag can also be passed in, and it marks the result illegal.

Top module: `vtype_limit_unit`

## Requirements
- R1: After reset, `outValid`, `outIllegal` and `vlmaxOut` are all 0.
- R2: `outValid` is 1 in the cycle after each clock edge that samples `inStrobe` high, and is 0 after an edge that samples it low.
- R3: The element-width code is `vtypeIn[5:3]` and the multiplier code is `vtypeIn[2:0]`. Any bits above bit 5 have no effect on the result.
- R4: A captured request with `villIn` = 1 gives `outIllegal` = 1.
- R5: A captured element-width code of 4 to 7 gives `outIllegal` = 1.
- R6: A captured multiplier code of 3'b100 gives `outIllegal` = 1.
- R7: For a legal request, `vlmaxOut` = `VLEN >> (sew + 3 - e)`. Here sew is the element-width code. The exponent e is 0, 1, 2 or 3 for multiplier codes 000 to 011, and −3, −2 or −1 for codes 101, 110 and 111. With `VLEN` = 256, code 1 and multiplier 1/8, the result is 2.
- R8: With `perRegSel` = 1, a positive exponent is replaced by 0 before the shift. Fractional and unit exponents are unchanged, so the result never exceeds `VLEN >> (sew + 3)`.
- R9: Whenever `outIllegal` is 1, `vlmaxOut` is 0.
- R10: In a cycle whose edge samples `inStrobe` low, `outIllegal` and `vlmaxOut` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inStrobe | input | 1 | Request: capture the inputs at this edge |
| vtypeIn | input | VTYPE_W | Vector type word |
| villIn | input | 1 | External invalid-configuration flag |
| perRegSel | input | 1 | 1: limit the result to a single register |
| outValid | output | 1 | One-cycle pulse, result updated |
| outIllegal | output | 1 | Registered illegal-configuration flag |
| vlmaxOut | output | $clog2(VLEN)+1 | Registered maximum vector length |

## Verification
The bench targets the sign handling of the multiplier exponent.

- A design that treats codes 101 to 111 as unsigned would return 0 or a huge shift instead of 2 for the 1/8 case.
- The widest legal shift, nine places, must give 0 without wrapping to a large value.
- The largest legal result, 256, needs the extra top bit of `vlmaxOut`.

Per-register mode is tested with both positive and fractional exponents. A clamp that also touched negative exponents would change the 1/4 case.

Each of the three illegal sources is driven on its own. This catches a missing term, or a length that is not forced to zero.

Upper type bits are set on a legal word. Held outputs are checked while the inputs change with no strobe.

// File: rtl/vtype_limit_pkg.sv
package vtype_limit_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;   // load decode result into the output registers
    logic pulse;     // next value of the valid strobe
  } ctrl_strobe_t;

  localparam int SEW_FIELD_LO  = 3;
  localparam int LMUL_FIELD_LO = 0;
  localparam int CODE_W        = 3;
  localparam logic [CODE_W-1:0] LMUL_RESERVED = 3'b100;

endpackage

// File: rtl/vtype_limit_ctrl.sv
module vtype_limit_ctrl
  import vtype_limit_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inStrobe,
  output ctrl_strobe_t strobes,
  output logic         validQ
);

  always_comb begin
    strobes.capture = inStrobe;
    strobes.pulse   = inStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobes.pulse;
  end

endmodule

// File: rtl/vtype_limit_dp.sv
module vtype_limit_dp
  import vtype_limit_pkg::*;
#(
  parameter int VLEN    = 256,
  parameter int VTYPE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strobe_t               strobes,
  input  logic [VTYPE_W-1:0]         vtypeIn,
  input  logic                       villIn,
  input  logic                       perRegSel,
  output logic                       illegalQ,
  output logic [$clog2(VLEN):0]      vlmaxQ
);

  localparam int CNT_W   = $clog2(VLEN) + 1;
  localparam int SHIFT_W = 5;   // covers sew(0..7) + 3 - exp(-3..3)
  localparam logic [CNT_W-1:0] VLEN_VEC = CNT_W'(VLEN);

  logic [CODE_W-1:0]        sewCode;
  logic [CODE_W-1:0]        lmulCode;
  logic signed [CODE_W:0]   lmulExp;
  logic signed [CODE_W:0]   effExp;
  logic signed [SHIFT_W-1:0] shiftAmt;
  logic                     illegalNext;
  logic [CNT_W-1:0]         vlmaxNext;

  always_comb begin
    sewCode  = vtypeIn[SEW_FIELD_LO +: CODE_W];
    lmulCode = vtypeIn[LMUL_FIELD_LO +: CODE_W];
    // Sign-extended exponent: 101..111 become -3..-1
    lmulExp  = {lmulCode[CODE_W-1], lmulCode};
    // Single-register limit: positive exponents fold to 0
    effExp   = (perRegSel && !lmulExp[CODE_W]) ? '0 : lmulExp;
    shiftAmt = $signed({2'b00, sewCode}) + 5'sd3
               - $signed({effExp[CODE_W], effExp});
    illegalNext = villIn || sewCode[CODE_W-1] || (lmulCode == LMUL_RESERVED);
    if (illegalNext || shiftAmt[SHIFT_W-1]) vlmaxNext = '0;
    else vlmaxNext = VLEN_VEC >> shiftAmt[SHIFT_W-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      illegalQ <= 1'b0;
      vlmaxQ   <= '0;
    end else if (strobes.capture) begin
      illegalQ <= illegalNext;
      vlmaxQ   <= vlmaxNext;
    end
  end

endmodule

// File: rtl/vtype_limit_unit.sv
module vtype_limit_unit
  import vtype_limit_pkg::*;
#(
  parameter int VLEN    = 256,
  parameter int VTYPE_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inStrobe,
  input  logic [VTYPE_W-1:0]     vtypeIn,
  input  logic                   villIn,
  input  logic                   perRegSel,
  output logic                   outValid,
  output logic                   outIllegal,
  output logic [$clog2(VLEN):0]  vlmaxOut
);

  ctrl_strobe_t strobes;

  vtype_limit_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inStrobe (inStrobe),
    .strobes  (strobes),
    .validQ   (outValid)
  );

  vtype_limit_dp #(.VLEN(VLEN), .VTYPE_W(VTYPE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .vtypeIn   (vtypeIn),
    .villIn    (villIn),
    .perRegSel (perRegSel),
    .illegalQ  (outIllegal),
    .vlmaxQ    (vlmaxOut)
  );

endmodule

// File: rtl/vtype_limit_chk.sv
module vtype_limit_chk #(
  parameter int VLEN    = 256,
  parameter int VTYPE_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inStrobe,
  input logic [VTYPE_W-1:0]    vtypeIn,
  input logic                  villIn,
  input logic                  perRegSel,
  input logic                  outValid,
  input logic                  outIllegal,
  input logic [$clog2(VLEN):0] vlmaxOut
);

  localparam int CNT_W = $clog2(VLEN) + 1;
  localparam logic [CNT_W-1:0] ONE_REG = CNT_W'(VLEN / 8);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inStrobe |=> outValid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inStrobe |=> !outValid);
  assert_vill_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && villIn) |=> outIllegal);
  assert_sew_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && vtypeIn[5]) |=> outIllegal);
  assert_lmul_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && vtypeIn[2:0] == 3'b100) |=> outIllegal);
  assert_perreg_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && perRegSel) |=> (vlmaxOut <= ONE_REG));
  assert_zero_on_illegal_R9: assert property (@(posedge clk) disable iff (!rstN)
    outIllegal |-> (vlmaxOut == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inStrobe |=> ($stable(vlmaxOut) && $stable(outIllegal)));

endmodule

bind vtype_limit_unit vtype_limit_chk #(.VLEN(VLEN), .VTYPE_W(VTYPE_W)) u_chk (
  .clk(clk), .rstN(rstN), .inStrobe(inStrobe), .vtypeIn(vtypeIn),
  .villIn(villIn), .perRegSel(perRegSel), .outValid(outValid),
  .outIllegal(outIllegal), .vlmaxOut(vlmaxOut)
);

// File: tb/vtype_limit_unit_tb.sv
module vtype_limit_unit_tb;

  localparam int VLEN    = 256;
  localparam int VTYPE_W = 8;
  localparam int CNT_W   = $clog2(VLEN) + 1;
  localparam int NVEC    = 16;

  // {vtype[7:0], vill, perReg, expIllegal, expVlmax[15:0]}
  localparam logic [26:0] VECS [NVEC] = '{
    {8'h00, 1'b0, 1'b0, 1'b0, 16'd32},   // R7 sew0 x1
    {8'h0D, 1'b0, 1'b0, 1'b0, 16'd2},    // R7 sew1 x1/8 -> 2
    {8'h03, 1'b0, 1'b0, 1'b0, 16'd256},  // R7 sew0 x8, full width
    {8'h03, 1'b0, 1'b1, 1'b0, 16'd32},   // R8 clamp x8 to x1
    {8'h1D, 1'b0, 1'b0, 1'b0, 16'd0},    // R7 sew3 x1/8, shift 9
    {8'h17, 1'b0, 1'b0, 1'b0, 16'd4},    // R7 sew2 x1/2
    {8'h19, 1'b0, 1'b0, 1'b0, 16'd8},    // R7 sew3 x2
    {8'h19, 1'b0, 1'b1, 1'b0, 16'd4},    // R8 clamp x2
    {8'h12, 1'b0, 1'b0, 1'b0, 16'd32},   // R7 sew2 x4
    {8'h0E, 1'b0, 1'b1, 1'b0, 16'd4},    // R8 fractional x1/4 unchanged
    {8'hCD, 1'b0, 1'b0, 1'b0, 16'd2},    // R3 upper bits ignored
    {8'h20, 1'b0, 1'b0, 1'b1, 16'd0},    // R5 sew code 4, R9
    {8'h38, 1'b0, 1'b0, 1'b1, 16'd0},    // R5 sew code 7, R9
    {8'h04, 1'b0, 1'b0, 1'b1, 16'd0},    // R6 reserved multiplier, R9
    {8'h0C, 1'b0, 1'b1, 1'b1, 16'd0},    // R6 reserved, per-register
    {8'h00, 1'b1, 1'b0, 1'b1, 16'd0}     // R4 vill set, R9
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inStrobe = 1'b0;
  logic [VTYPE_W-1:0] vtypeIn = '0;
  logic villIn = 1'b0;
  logic perRegSel = 1'b0;
  logic outValid;
  logic outIllegal;
  logic [CNT_W-1:0] vlmaxOut;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  vtype_limit_unit #(.VLEN(VLEN), .VTYPE_W(VTYPE_W)) u_dut (
    .clk(clk), .rstN(rstN), .inStrobe(inStrobe), .vtypeIn(vtypeIn),
    .villIn(villIn), .perRegSel(perRegSel), .outValid(outValid),
    .outIllegal(outIllegal), .vlmaxOut(vlmaxOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at a negedge, let one posedge capture, sample at the next negedge
  task automatic apply(input logic [7:0] vt, input logic vl, input logic pr);
    vtypeIn = vt; villIn = vl; perRegSel = pr; inStrobe = 1'b1;
    @(negedge clk);
    inStrobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid at reset", int'(outValid), 0);
    check("R1 illegal at reset", int'(outIllegal), 0);
    check("R1 vlmax at reset", int'(vlmaxOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i][26:19], VECS[i][18], VECS[i][17]);
      check($sformatf("R2 valid row %0d", i), int'(outValid), 1);
      check($sformatf("R3..R9 illegal row %0d", i), int'(outIllegal),
            int'(VECS[i][16]));
      check($sformatf("R3..R9 vlmax row %0d", i), int'(vlmaxOut),
            int'(VECS[i][15:0]));
    end

    // R2 pulse ends; R10 hold while inputs change without a strobe
    apply(8'h0D, 1'b0, 1'b0);
    vtypeIn = 8'h20; villIn = 1'b1; perRegSel = 1'b1;
    @(negedge clk);
    check("R2 valid drops", int'(outValid), 0);
    check("R10 vlmax held", int'(vlmaxOut), 2);
    check("R10 illegal held", int'(outIllegal), 0);
    @(negedge clk);
    check("R10 vlmax still held", int'(vlmaxOut), 2);

    // Back-to-back strobes: R2 valid stays high, R7 each result lands in turn
    vtypeIn = 8'h03; villIn = 1'b0; perRegSel = 1'b0; inStrobe = 1'b1;
    @(negedge clk);
    check("R7 back-to-back first", int'(vlmaxOut), 256);
    vtypeIn = 8'h17;
    @(negedge clk);
    inStrobe = 1'b0;
    check("R2 valid back-to-back", int'(outValid), 1);
    check("R7 back-to-back second", int'(vlmaxOut), 4);

    // R9 illegal after legal clears vlmax
    apply(8'h04, 1'b0, 1'b0);
    check("R9 vlmax zero", int'(vlmaxOut), 0);
    check("R6 illegal", int'(outIllegal), 1);

    // R1 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R1 illegal after reset", int'(outIllegal), 0);
    rstN = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule